// File: doc/BRIEF.md
# Programmable One-Shot Pulse Generator

This block is a digitally timed monostable. An asynchronous trigger input is brought into the clock domain, and its rising edges are detected. An accepted edge starts exactly one output pulse. The pulse length is a master period, given in clock cycles, multiplied by a divider ratio. A 4-bit configuration code selects the divider ratio from a geometric series, and the same code selects the output polarity.

The ratio assignment is mirrored about the middle of the code range. Each code and its complement select the same ratio but opposite polarities. The code and the master period are captured when a trigger is accepted and held for the whole pulse. Edges that arrive while a pulse is running are dropped.

All pins are plain control and status levels. No data stream enters or leaves the block, so it has no valid/ready handshake and never applies back-pressure. A busy flag mirrors the internal active state. The output pin is that state combined with the selected polarity.

Top module: `osp_oneshot`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy` is 0 and `pulse_out` is 0.
- R2: The trigger passes through a two-flop synchronizer and then a rising-edge detector. When `trig` goes high while idle, `busy` is 1 from the third rising clock edge after the change.
- R3: A pulse keeps `busy` high for exactly ratio × P clock cycles. P is the captured master period. The ratio is 2^(DIV_SHIFT·k), where k = code for codes 0–7 and k = 15 − code for codes 8–15. With the default DIV_SHIFT = 3 the ratios are 1, 8, 64, 512, 4096, 2^15, 2^18 and 2^21.
- R4: Codes c and 15 − c give pulses of equal length.
- R5: Codes 0–7 select polarity 0 and codes 8–15 select polarity 1. `pulse_out` equals `busy` XOR polarity, so polarity-1 pulses are low-going.
- R6: A rising trigger edge that arrives while `busy` is 1 is ignored. It does not change the length of the running pulse, and no pulse follows it.
- R7: A trigger held high produces only one pulse, because only edges start pulses.
- R8: The code and the master period are sampled when a trigger is accepted. Changes to either during a pulse affect neither its length nor its output level.
- R9: A master period of 0 is treated as 1, so the pulse lasts the ratio in cycles.
- R10: While idle, `pulse_out` follows the polarity of the current code, one cycle after the code changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Asynchronous trigger; rising edges start pulses |
| cfg_code | input | 4 | Divider-ratio and polarity selection code |
| master_period | input | PERIOD_W | Master period in clock cycles (0 treated as 1) |
| pulse_out | output | 1 | One-shot output, polarity applied |
| busy | output | 1 | High while a pulse is running |

## Verification
The main pattern sweeps all sixteen codes against master periods 0 to 3, with a small divider step. Each pulse's measured length, start latency and output level are compared with values computed from the code arithmetic. This separates ratio-index errors, mirror errors and zero-period handling. Pairing the lengths of complementary codes confirms the symmetry independently of the absolute values. Separate patterns cover three further cases: toggling the trigger mid-pulse, holding the trigger high past the end of a pulse, and rewriting the code and period during a pulse. These tell dropped edges apart from queued ones, and captured settings apart from live ones.

// File: rtl/osp_pkg.sv
package osp_pkg;
  localparam int NUM_SEL = 8;
  localparam int IDX_W   = $clog2(NUM_SEL);

  typedef struct packed {
    logic             pol;
    logic [IDX_W-1:0] idx;
  } osp_sel_t;
endpackage

// File: rtl/osp_trig_sync.sv
module osp_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  // An edge is reported for one cycle only (level-held trigger)
  assert_single_edge_R7: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/osp_code_decode.sv
module osp_code_decode
  import osp_pkg::*;
(
  input  logic [3:0] code_i,
  output osp_sel_t   sel_o
);
  // Upper half mirrors the lower half: index = 15 - code there
  always_comb begin
    sel_o.pol = code_i[3];
    sel_o.idx = code_i[3] ? ~code_i[IDX_W-1:0] : code_i[IDX_W-1:0];
  end
endmodule

// File: rtl/osp_timer.sv
module osp_timer
  import osp_pkg::*;
#(
  parameter int PERIOD_W  = 16,
  parameter int DIV_SHIFT = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic                done_o
);
  localparam int DC_W = DIV_SHIFT * (NUM_SEL - 1);

  logic [PERIOD_W-1:0] per_q, mc_q;
  logic [IDX_W-1:0]    idx_q;
  logic [DC_W-1:0]     dc_q;
  logic [DC_W-1:0]     term_tbl [NUM_SEL];
  logic                tick;

  // Terminal count of the divider chain for each ratio index
  for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_term
    assign term_tbl[gi] = DC_W'((64'(1) << (DIV_SHIFT * gi)) - 64'(1));
  end

  assign tick   = en_i && (mc_q == per_q - PERIOD_W'(1));
  assign done_o = tick && (dc_q == term_tbl[idx_q]);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= PERIOD_W'(1);
      idx_q <= '0;
      mc_q  <= '0;
      dc_q  <= '0;
    end else if (start_i) begin
      per_q <= (period_i == '0) ? PERIOD_W'(1) : period_i;
      idx_q <= idx_i;
      mc_q  <= '0;
      dc_q  <= '0;
    end else if (en_i) begin
      mc_q <= tick ? '0 : mc_q + PERIOD_W'(1);
      if (tick) dc_q <= dc_q + DC_W'(1);
    end
  end

  assert_master_range_R3: assert property (@(posedge clk) disable iff (rst)
    en_i |-> (mc_q < per_q));
  assert_period_floor_R9: assert property (@(posedge clk) disable iff (rst)
    en_i |-> (per_q != '0));
  assert_div_range_R3: assert property (@(posedge clk) disable iff (rst)
    en_i |-> (dc_q <= term_tbl[idx_q]));
endmodule

// File: rtl/osp_oneshot.sv
module osp_oneshot
  import osp_pkg::*;
#(
  parameter int PERIOD_W    = 16,
  parameter int DIV_SHIFT   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig,
  input  logic [3:0]          cfg_code,
  input  logic [PERIOD_W-1:0] master_period,
  output logic                pulse_out,
  output logic                busy
);
  logic     rise, start, done, active_q, pol_q;
  osp_sel_t sel;

  osp_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(trig), .rise_o(rise)
  );

  osp_code_decode u_dec (.code_i(cfg_code), .sel_o(sel));

  assign start = rise && !active_q;

  osp_timer #(.PERIOD_W(PERIOD_W), .DIV_SHIFT(DIV_SHIFT)) u_tmr (
    .clk(clk), .rst(rst), .start_i(start), .en_i(active_q),
    .period_i(master_period), .idx_i(sel.idx), .done_o(done)
  );

  // Output latch; polarity tracks the code only while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pol_q    <= 1'b0;
    end else begin
      if (start)     active_q <= 1'b1;
      else if (done) active_q <= 1'b0;
      if (!active_q) pol_q <= sel.pol;
    end
  end

  assign busy      = active_q;
  assign pulse_out = active_q ^ pol_q;

  assert_start_sets_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  assert_done_clears_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  assert_level_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (busy && $stable(pulse_out)));
  assert_ignore_retrig_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && rise && !done) |=> busy);
endmodule

// File: tb/tb_osp_oneshot.sv
module tb_osp_oneshot;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trig = 1'b0;
  logic [3:0]    cfg_code = '0;
  logic [PW-1:0] master_period = '0;
  logic          pulse_out, busy;

  int checks = 0;
  int fails  = 0;
  int widths [16][4];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  osp_oneshot #(.PERIOD_W(PW), .DIV_SHIFT(1), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .trig(trig), .cfg_code(cfg_code),
    .master_period(master_period), .pulse_out(pulse_out), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_width(input int code, input int per);
    int k = (code < 8) ? code : 15 - code;
    return (1 << k) * ((per == 0) ? 1 : per);
  endfunction

  // Raise trig, measure latency to busy, width of busy, and output-level errors
  task automatic fire(input int pol, output int lat, output int width, output int perr);
    trig = 1'b1;
    lat = 0; width = 0; perr = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!busy && lat < 10);
    while (busy && width < 5000) begin
      width++;
      if (pulse_out !== (pol ? 1'b0 : 1'b1)) perr++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int lat, w, pe;
    bit stayed;
    // R1: reset state
    idle(3);
    check(busy === 1'b0 && pulse_out === 1'b0, "R1 in reset", {busy, pulse_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && pulse_out === 1'b0, "R1 after reset", {busy, pulse_out}, 0);

    // Sweep: every code against periods 0..3
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 4; p++) begin
        cfg_code = 4'(c);
        master_period = PW'(p);
        idle(2);
        check(pulse_out === (c >= 8), "R10 idle level", pulse_out, int'(c >= 8));
        fire(c >= 8, lat, w, pe);
        widths[c][p] = w;
        check(lat == 3, "R2 start latency", lat, 3);
        check(w == exp_width(c, p), (p == 0) ? "R9 zero period width" : "R3 width",
              w, exp_width(c, p));
        check(pe == 0, "R5 output level errors", pe, 0);
        trig = 1'b0;
        idle(4);
      end
    end

    // R4: complementary codes give equal widths
    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 4; p++)
        check(widths[c][p] == widths[15-c][p], "R4 mirror width",
              widths[c][p], widths[15-c][p]);

    // R6: edge during pulse ignored (code 2 ratio 4, period 3 -> 12)
    cfg_code = 4'd2; master_period = PW'(3);
    idle(2);
    trig = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!busy && lat < 10);
    w = 1;
    trig = 1'b0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (busy) w++; end
    trig = 1'b1;
    while (busy && w < 5000) begin @(negedge clk); if (busy) w++; end
    check(w == 12, "R6 width unchanged by mid-pulse edge", w, 12);
    stayed = 1'b1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (busy) stayed = 1'b0; end
    check(stayed, "R6 no pulse after dropped edge", int'(!stayed), 0);

    // R7: trigger held high gives one pulse only
    trig = 1'b0; idle(4);
    cfg_code = 4'd1; master_period = PW'(2);
    idle(2);
    fire(0, lat, w, pe);
    check(w == 4, "R7 first pulse width", w, 4);
    stayed = 1'b1;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (busy) stayed = 1'b0; end
    check(stayed, "R7 no second pulse while held", int'(!stayed), 0);
    trig = 1'b0; idle(4);

    // R8: settings captured at start (code 3 period 2 -> 16, polarity 0)
    cfg_code = 4'd3; master_period = PW'(2);
    idle(2);
    trig = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!busy && lat < 10);
    cfg_code = 4'd9; master_period = PW'(5);
    w = 0; pe = 0;
    while (busy && w < 5000) begin
      w++;
      if (pulse_out !== 1'b1) pe++;
      @(negedge clk);
    end
    check(w == 16, "R8 width uses captured settings", w, 16);
    check(pe == 0, "R8 level uses captured polarity", pe, 0);
    @(negedge clk);
    check(pulse_out === 1'b1, "R10 idle level follows new code", pulse_out, 1);
    trig = 1'b0; idle(4);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule